// File: doc/BRIEF.md
# Descriptor-Chained Multi-Channel DMA Engine

This block moves data between memory locations on behalf of several independent channels that share a single memory master port. Each channel holds a source pointer, a destination pointer, a link pointer to a further descriptor, a control word carrying the remaining element count, the element widths, the increment enables and the completion-flag request, and a configuration word carrying enable, halt, peripheral numbers and a flow selector. Software loads these words through a small write port. Once the global enable is set, the engine picks a channel and copies one element. It reads the source in source-width pieces, packs the bytes into a four-byte staging register, and writes them out in destination-width pieces. It then counts the element down.

When a channel's count reaches zero, the channel either reloads itself from a four-word record in memory at its link pointer or switches itself off. It may also raise a sticky completion flag. Transfers can be made to wait on peripheral request lines: the flow selector names which of the channel's source and destination request lines must be high. An unsupported selector raises a sticky error flag instead.

Top module: `dma_ll_engine`

## Requirements
- R1: Each element decrements the count in control bits [11:0] by one, and the upper control bits stay unchanged, so their increment and width settings keep applying to later elements. A channel whose count is zero makes no memory access and stays enabled.
- R2: A width code of 0 means 1 byte, 1 means 2 bytes and any larger value means 4 bytes. The source code is control[20:18] and the destination code is control[23:21]. The memory port gives the access size as mem_size = 0, 1 or 2 for 1, 2 or 4 bytes, with data in the low-order bytes, little-endian.
- R3: One element is the larger of the two widths. It takes (element / source width) reads, with bytes placed in ascending order, followed by (element / destination width) writes taken in the same byte order.
- R4: Control bit 26 set makes the source address advance by the source width after every read. Control bit 27 set makes the destination address advance by the destination width after every write. When a bit is clear, that address stays fixed.
- R5: A channel is eligible only while configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0.
- R6: The flow selector in configuration bits [13:11] gates transfers. Value 0 needs no request. Value 1 needs the request line numbered by configuration bits [10:6]. Value 2 needs the line numbered by bits [5:1]. Value 3 needs both lines. Request lines that are not named have no effect.
- R7: When the count reaches zero and the link pointer P is non-zero, the engine reads P+0 (source), P+4 (destination), P+12 (control) and P+8 (new link), in that order, and installs them. When P is zero, the channel clears its enable bit.
- R8: A channel's completion flag is set when its count reaches zero, only if control bit 31 of the word in force after any reload is 1. The flag stays set until its tc_clr bit is pulsed.
- R9: An enabled, unhalted channel with flow selector 4 to 7 makes no access and raises its error flag. The flag can be cleared through err_clr once the channel no longer requests it.
- R10: With glb_en low, no new element starts.
- R11: When the engine is free, it serves the last-served channel if that channel is still eligible. Otherwise it serves the lowest-numbered eligible channel, so a channel keeps the port until it has no eligible work.
- R12: Once mem_req is raised, mem_req, mem_addr, mem_we and mem_size hold steady until a cycle in which mem_ready is high completes the access.
- R13: The write port loads word prog_sel of channel prog_chan (0 source, 1 destination, 2 link, 3 control, 4 configuration). A channel number at or above the channel count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global engine enable |
| prog_we | input | 1 | Channel word write strobe |
| prog_chan | input | CW | Channel number for the write |
| prog_sel | input | 3 | Word select for the write |
| prog_data | input | 32 | Write data |
| periph_req | input | 32 | Peripheral request lines |
| tc_clr | input | NCH | Completion flag clear, one per channel |
| err_clr | input | NCH | Error flag clear, one per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, low-order aligned |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, low-order aligned |
| chan_en | output | NCH | Enable bit of each channel |
| tc_flag | output | NCH | Sticky completion flags |
| err_flag | output | NCH | Sticky error flags |

## Verification
The bench builds the engine with three channels. The channel number port is then two bits wide and can carry the value 3, which names no channel, so the rule that an out-of-range write is ignored can be checked. Three channels are also enough to show that the lowest-numbered channel wins arbitration and that the channel being served keeps the port while a lower-numbered one becomes ready. The memory model stalls one cycle in four, so every access has to hold its request through wait states.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CNT_W       = 12;
  localparam int unsigned REQ_LINES   = 32;
  localparam int unsigned CTL_SW_LSB  = 18;
  localparam int unsigned CTL_DW_LSB  = 21;
  localparam int unsigned CTL_SRC_INC = 26;
  localparam int unsigned CTL_DST_INC = 27;
  localparam int unsigned CTL_IRQ     = 31;
  localparam int unsigned CFG_EN      = 0;
  localparam int unsigned CFG_SP_LSB  = 1;
  localparam int unsigned CFG_DP_LSB  = 6;
  localparam int unsigned CFG_FLOW_LSB = 11;
  localparam int unsigned CFG_HALT    = 18;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_LINK = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_CONF = 3'd4;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_READ,
    MV_WRITE,
    MV_LOAD
  } mv_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] lli;
    logic [WORD_W-1:0] ctrl;
  } chan_ctx_t;

  function automatic logic [2:0] width_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [2:0] code);
    return (code > 3'd2) ? 2'd2 : code[1:0];
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_ll_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic                 prog_we,
  input  logic [CW-1:0]        prog_chan,
  input  logic [2:0]           prog_sel,
  input  logic [WORD_W-1:0]    prog_data,
  input  logic [REQ_LINES-1:0] periph_req,
  input  logic                 wb_valid,
  input  logic [CW-1:0]        wb_chan,
  input  chan_ctx_t            wb_ctx,
  input  logic                 wb_clr_en,
  input  logic                 wb_tc,
  input  logic [NCH-1:0]       tc_clr,
  input  logic [NCH-1:0]       err_clr,
  output chan_ctx_t            ctx_o [NCH],
  output logic [NCH-1:0]       elig,
  output logic [NCH-1:0]       chan_en,
  output logic [NCH-1:0]       tc_flag,
  output logic [NCH-1:0]       err_flag
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WORD_W-1:0] src_q, dst_q, lli_q, ctrl_q;
    logic              en_q, halt_q;
    logic [4:0]        sp_q, dp_q;
    logic [2:0]        flow_q;
    logic              tc_q, err_q;
    logic              prog_hit, wb_hit, gate_ok, bad_flow, active;

    assign prog_hit = prog_we && (prog_chan == CW'(c));
    assign wb_hit   = wb_valid && (wb_chan == CW'(c));
    assign active   = glb_en && en_q && !halt_q;

    always_comb begin
      case (flow_q)
        3'd0:    gate_ok = 1'b1;
        3'd1:    gate_ok = periph_req[dp_q];
        3'd2:    gate_ok = periph_req[sp_q];
        3'd3:    gate_ok = periph_req[sp_q] && periph_req[dp_q];
        default: gate_ok = 1'b0;
      endcase
    end

    assign bad_flow = active && flow_q[2];
    assign elig[c]  = active && gate_ok && (ctrl_q[CNT_W-1:0] != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        src_q  <= '0;
        dst_q  <= '0;
        lli_q  <= '0;
        ctrl_q <= '0;
        en_q   <= 1'b0;
        halt_q <= 1'b0;
        sp_q   <= '0;
        dp_q   <= '0;
        flow_q <= '0;
        tc_q   <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (wb_hit) begin
          src_q  <= wb_ctx.src;
          dst_q  <= wb_ctx.dst;
          lli_q  <= wb_ctx.lli;
          ctrl_q <= wb_ctx.ctrl;
          if (wb_clr_en) en_q <= 1'b0;
        end
        if (prog_hit) begin
          case (prog_sel)
            SEL_SRC:  src_q  <= prog_data;
            SEL_DST:  dst_q  <= prog_data;
            SEL_LINK: lli_q  <= prog_data;
            SEL_CTRL: ctrl_q <= prog_data;
            SEL_CONF: begin
              en_q   <= prog_data[CFG_EN];
              sp_q   <= prog_data[CFG_SP_LSB +: 5];
              dp_q   <= prog_data[CFG_DP_LSB +: 5];
              flow_q <= prog_data[CFG_FLOW_LSB +: 3];
              halt_q <= prog_data[CFG_HALT];
            end
            default: ;
          endcase
        end
        if (wb_hit && wb_tc) tc_q <= 1'b1;
        else if (tc_clr[c])  tc_q <= 1'b0;
        if (bad_flow)        err_q <= 1'b1;
        else if (err_clr[c]) err_q <= 1'b0;
      end
    end

    assign ctx_o[c]    = '{src: src_q, dst: dst_q, lli: lli_q, ctrl: ctrl_q};
    assign chan_en[c]  = en_q;
    assign tc_flag[c]  = tc_q;
    assign err_flag[c] = err_q;
  end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH-1:0] elig,
  input  logic [CW-1:0]  last,
  output logic           any,
  output logic [CW-1:0]  grant
);

  logic [CW-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) lowest = CW'(i);
    end
  end

  assign any   = |elig;
  assign grant = elig[last] ? last : lowest;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_ll_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any,
  input  logic [CW-1:0]     grant,
  input  chan_ctx_t         ctx_in,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [CW-1:0]     last,
  output logic              wb_valid,
  output logic [CW-1:0]     wb_chan,
  output chan_ctx_t         wb_ctx,
  output logic              wb_clr_en,
  output logic              wb_tc
);

  mv_state_t         state_q;
  logic [CW-1:0]     ch_q;
  logic [WORD_W-1:0] w_src, w_dst, w_lli, w_ctrl;
  logic [3:0][7:0]   stg_q;
  logic [3:0]        off_q;
  logic [1:0]        ldk_q;

  logic [2:0]        sw, dw, xs;
  logic [3:0][7:0]   stg_next, rd_bytes;
  logic [3:0]        roff_next, woff_next;
  logic [WORD_W-1:0] src_next, dst_next, ctrl_dec, ld_addr_next;
  logic              rd_last, wr_last, cnt_zero;

  function automatic logic [WORD_W-1:0] pick_bytes(input logic [3:0][7:0] bb,
                                                   input logic [3:0] o);
    logic [3:0][7:0] r;
    logic [3:0]      idx;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      idx = o + 4'(b);
      if (idx < 4'd4) r[b] = bb[idx[1:0]];
    end
    return r;
  endfunction

  assign rd_bytes = mem_rdata;

  always_comb begin
    sw = width_bytes(w_ctrl[CTL_SW_LSB +: 3]);
    dw = width_bytes(w_ctrl[CTL_DW_LSB +: 3]);
    xs = (sw > dw) ? sw : dw;
    stg_next = stg_q;
    for (int b = 0; b < 4; b++) begin
      if ((4'(b) >= off_q) && (4'(b) < off_q + {1'b0, sw}))
        stg_next[b] = rd_bytes[2'(4'(b) - off_q)];
    end
    roff_next = off_q + {1'b0, sw};
    woff_next = off_q + {1'b0, dw};
    rd_last   = roff_next >= {1'b0, xs};
    wr_last   = woff_next >= {1'b0, xs};
    src_next  = w_src + (w_ctrl[CTL_SRC_INC] ? 32'(sw) : 32'd0);
    dst_next  = w_dst + (w_ctrl[CTL_DST_INC] ? 32'(dw) : 32'd0);
    ctrl_dec  = {w_ctrl[WORD_W-1:CNT_W], w_ctrl[CNT_W-1:0] - 12'd1};
    cnt_zero  = (ctrl_dec[CNT_W-1:0] == '0);
    case (ldk_q)
      2'd0:    ld_addr_next = w_lli + 32'd4;
      2'd1:    ld_addr_next = w_lli + 32'd12;
      default: ld_addr_next = w_lli + 32'd8;
    endcase
  end

  always_comb begin
    wb_valid  = 1'b0;
    wb_clr_en = 1'b0;
    wb_tc     = 1'b0;
    wb_chan   = ch_q;
    wb_ctx    = '{src: w_src, dst: dst_next, lli: w_lli, ctrl: ctrl_dec};
    if (state_q == MV_WRITE && mem_ready && wr_last) begin
      if (!cnt_zero) begin
        wb_valid = 1'b1;
      end else if (w_lli == '0) begin
        wb_valid  = 1'b1;
        wb_clr_en = 1'b1;
        wb_tc     = w_ctrl[CTL_IRQ];
      end
    end else if (state_q == MV_LOAD && mem_ready && ldk_q == 2'd3) begin
      wb_valid = 1'b1;
      wb_tc    = w_ctrl[CTL_IRQ];
      wb_ctx   = '{src: w_src, dst: w_dst, lli: mem_rdata, ctrl: w_ctrl};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MV_IDLE;
      ch_q      <= '0;
      last      <= '0;
      w_src     <= '0;
      w_dst     <= '0;
      w_lli     <= '0;
      w_ctrl    <= '0;
      stg_q     <= '0;
      off_q     <= '0;
      ldk_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state_q)
        MV_IDLE: begin
          if (any) begin
            ch_q     <= grant;
            last     <= grant;
            w_src    <= ctx_in.src;
            w_dst    <= ctx_in.dst;
            w_lli    <= ctx_in.lli;
            w_ctrl   <= ctx_in.ctrl;
            stg_q    <= '0;
            off_q    <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ctx_in.src;
            mem_size <= size_code(ctx_in.ctrl[CTL_SW_LSB +: 3]);
            state_q  <= MV_READ;
          end
        end
        MV_READ: begin
          if (mem_ready) begin
            stg_q <= stg_next;
            w_src <= src_next;
            if (rd_last) begin
              off_q     <= '0;
              mem_we    <= 1'b1;
              mem_addr  <= w_dst;
              mem_size  <= size_code(w_ctrl[CTL_DW_LSB +: 3]);
              mem_wdata <= pick_bytes(stg_next, 4'd0);
              state_q   <= MV_WRITE;
            end else begin
              off_q    <= roff_next;
              mem_addr <= src_next;
            end
          end
        end
        MV_WRITE: begin
          if (mem_ready) begin
            w_dst <= dst_next;
            if (wr_last) begin
              w_ctrl <= ctrl_dec;
              mem_we <= 1'b0;
              if (cnt_zero && w_lli != '0) begin
                ldk_q    <= 2'd0;
                mem_addr <= w_lli;
                mem_size <= 2'd2;
                state_q  <= MV_LOAD;
              end else begin
                mem_req <= 1'b0;
                state_q <= MV_IDLE;
              end
            end else begin
              off_q     <= woff_next;
              mem_addr  <= dst_next;
              mem_wdata <= pick_bytes(stg_q, woff_next);
            end
          end
        end
        MV_LOAD: begin
          if (mem_ready) begin
            case (ldk_q)
              2'd0:    w_src  <= mem_rdata;
              2'd1:    w_dst  <= mem_rdata;
              2'd2:    w_ctrl <= mem_rdata;
              default: w_lli  <= mem_rdata;
            endcase
            if (ldk_q == 2'd3) begin
              mem_req <= 1'b0;
              state_q <= MV_IDLE;
            end else begin
              ldk_q    <= ldk_q + 2'd1;
              mem_addr <= ld_addr_next;
            end
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_ll_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic                 prog_we,
  input  logic [CW-1:0]        prog_chan,
  input  logic [2:0]           prog_sel,
  input  logic [WORD_W-1:0]    prog_data,
  input  logic [REQ_LINES-1:0] periph_req,
  input  logic [NCH-1:0]       tc_clr,
  input  logic [NCH-1:0]       err_clr,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [WORD_W-1:0]    mem_addr,
  output logic [1:0]           mem_size,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_ready,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic [NCH-1:0]       chan_en,
  output logic [NCH-1:0]       tc_flag,
  output logic [NCH-1:0]       err_flag
);

  chan_ctx_t      ctx_arr [NCH];
  chan_ctx_t      grant_ctx, wb_ctx;
  logic [NCH-1:0] elig;
  logic           any, wb_valid, wb_clr_en, wb_tc;
  logic [CW-1:0]  grant, last, wb_chan;

  dma_chan_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .glb_en(glb_en),
    .prog_we(prog_we), .prog_chan(prog_chan), .prog_sel(prog_sel),
    .prog_data(prog_data), .periph_req(periph_req),
    .wb_valid(wb_valid), .wb_chan(wb_chan), .wb_ctx(wb_ctx),
    .wb_clr_en(wb_clr_en), .wb_tc(wb_tc),
    .tc_clr(tc_clr), .err_clr(err_clr),
    .ctx_o(ctx_arr), .elig(elig), .chan_en(chan_en),
    .tc_flag(tc_flag), .err_flag(err_flag)
  );

  dma_arbiter #(.NCH(NCH), .CW(CW)) u_arb (
    .elig(elig), .last(last), .any(any), .grant(grant)
  );

  assign grant_ctx = ctx_arr[grant];

  dma_mover #(.CW(CW)) u_mover (
    .clk(clk), .rst(rst), .any(any), .grant(grant), .ctx_in(grant_ctx),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .last(last),
    .wb_valid(wb_valid), .wb_chan(wb_chan), .wb_ctx(wb_ctx),
    .wb_clr_en(wb_clr_en), .wb_tc(wb_tc)
  );

endmodule

// File: rtl/dma_ll_checker.sv
module dma_ll_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           glb_en,
  input logic           prog_we,
  input logic           mem_req,
  input logic           mem_we,
  input logic [31:0]    mem_addr,
  input logic [1:0]     mem_size,
  input logic           mem_ready,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] tc_flag,
  input logic [NCH-1:0] err_flag
);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_size)));

  p_size_legal_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'd3));

  p_tc_after_beat_r8: assert property (@(posedge clk) disable iff (rst)
    ((tc_flag & ~$past(tc_flag)) != '0) |-> $past(mem_req && mem_ready));

  p_en_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(chan_en) & ~chan_en) != '0) |->
      $past((mem_req && mem_ready) || prog_we));

  p_err_needs_glb_r9: assert property (@(posedge clk) disable iff (rst)
    ((err_flag & ~$past(err_flag)) != '0) |-> $past(glb_en));

  p_no_start_off_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!glb_en) && $past(!mem_req)) |-> !mem_req);

endmodule

bind dma_ll_engine dma_ll_checker #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_ll_engine_bench.sv
module dma_ll_engine_bench;

  localparam int NCH = 3;
  localparam int CW  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           glb_en = 1'b0;
  logic           prog_we = 1'b0;
  logic [CW-1:0]  prog_chan = '0;
  logic [2:0]     prog_sel = '0;
  logic [31:0]    prog_data = '0;
  logic [31:0]    periph_req = '0;
  logic [NCH-1:0] tc_clr = '0;
  logic [NCH-1:0] err_clr = '0;
  logic           mem_req, mem_we, mem_ready;
  logic [31:0]    mem_addr, mem_wdata, mem_rdata;
  logic [1:0]     mem_size;
  logic [NCH-1:0] chan_en, tc_flag, err_flag;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_ll_engine #(.NCH(NCH)) u_dma_ll_engine (
    .clk(clk), .rst(rst), .glb_en(glb_en), .prog_we(prog_we),
    .prog_chan(prog_chan), .prog_sel(prog_sel), .prog_data(prog_data),
    .periph_req(periph_req), .tc_clr(tc_clr), .err_clr(err_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .chan_en(chan_en), .tc_flag(tc_flag),
    .err_flag(err_flag)
  );

  // memory model: byte array, stalls one cycle in four
  logic [7:0]  mem [0:4095];
  logic [1:0]  rdy_cnt = 2'd0;
  logic [31:0] t_addr [0:511];
  logic        t_we   [0:511];
  logic [1:0]  t_size [0:511];
  int          tn = 0;
  logic        p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;
  logic [1:0]  p_size = '0;
  int          hs_viol = 0;

  assign mem_ready = (rdy_cnt != 2'd0);

  always_comb begin
    for (int b = 0; b < 4; b++)
      mem_rdata[8*b +: 8] = mem[mem_addr[11:0] + 12'(b)];
  end

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    if (!rst) begin
      if (p_req && !p_rdy &&
          (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_size != p_size))
        hs_viol = hs_viol + 1;
      if (mem_req && mem_ready) begin
        if (tn < 512) begin
          t_addr[tn] = mem_addr;
          t_we[tn]   = mem_we;
          t_size[tn] = mem_size;
          tn = tn + 1;
        end
        if (mem_we) begin
          for (int b = 0; b < (1 << mem_size); b++)
            mem[mem_addr[11:0] + 12'(b)] = mem_wdata[8*b +: 8];
        end
      end
    end
    p_req  = mem_req;
    p_rdy  = mem_ready;
    p_addr = mem_addr;
    p_we   = mem_we;
    p_size = mem_size;
  end

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(int cnt, int swc, int dwc, bit si, bit di, bit irq);
    return (32'(irq) << 31) | (32'(di) << 27) | (32'(si) << 26) |
           (32'(dwc) << 21) | (32'(swc) << 18) | 32'(cnt);
  endfunction

  function automatic logic [31:0] mk_conf(bit en, int sp, int dp, int flow, bit halt);
    return (32'(halt) << 18) | (32'(flow) << 11) | (32'(dp) << 6) |
           (32'(sp) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] rd32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic prog(int ch, logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_chan = CW'(ch); prog_sel = sel; prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic setup(int ch, int s, int d, int lli, logic [31:0] ctrl, logic [31:0] conf);
    prog(ch, 3'd0, 32'(s));
    prog(ch, 3'd1, 32'(d));
    prog(ch, 3'd2, 32'(lli));
    prog(ch, 3'd3, ctrl);
    prog(ch, 3'd4, conf);
  endtask

  task automatic wait_off(int ch, string req);
    int t = 0;
    while (chan_en[ch] && t < 5000) begin @(negedge clk); t++; end
    n_checks++;
    if (t >= 5000) begin
      n_fail++;
      $display("FAIL %s channel %0d never finished: actual=busy expected=done", req, ch);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(string req, int a_src, int a_dst, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[a_dst+i] !== mem[a_src+i]) bad++;
    check_eq(req, "byte copy mismatches", 32'(bad), 32'd0);
  endtask

  function automatic int first_wr(int base, int lo, int hi);
    for (int i = base; i < tn; i++)
      if (t_we[i] && t_addr[i] >= 32'(lo) && t_addr[i] < 32'(hi)) return i;
    return -1;
  endfunction

  function automatic int last_wr(int base, int lo, int hi);
    int r = -1;
    for (int i = base; i < tn; i++)
      if (t_we[i] && t_addr[i] >= 32'(lo) && t_addr[i] < 32'(hi)) r = i;
    return r;
  endfunction

  task automatic expect_quiet(string req, int cycles);
    int base = tn;
    repeat (cycles) @(negedge clk);
    check_eq(req, "beats while not eligible", 32'(tn - base), 32'd0);
  endtask

  task automatic t_reset();
    check_eq("R13", "reset chan_en", 32'(chan_en), 32'd0);
    check_eq("R8", "reset tc_flag", 32'(tc_flag), 32'd0);
    check_eq("R9", "reset err_flag", 32'(err_flag), 32'd0);
    check_eq("R12", "reset mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_basic();
    int base = tn;
    int sz_bad = 0;
    setup(0, 'h100, 'h200, 0, mk_ctrl(4, 2, 2, 1, 1, 1), mk_conf(1, 0, 0, 0, 0));
    wait_off(0, "R1");
    check_eq("R1", "beats for 4 word elements", 32'(tn - base), 32'd8);
    cmp_bytes("R4", 'h100, 'h200, 16);
    for (int i = base; i < tn; i++) if (t_size[i] != 2'd2) sz_bad++;
    check_eq("R2", "word size code", 32'(sz_bad), 32'd0);
    check_eq("R8", "tc set with bit31", 32'(tc_flag[0]), 32'd1);
    @(negedge clk); tc_clr = 3'b001; @(negedge clk); tc_clr = '0; @(negedge clk);
    check_eq("R8", "tc cleared", 32'(tc_flag[0]), 32'd0);
  endtask

  task automatic t_fixed_src();
    int base = tn;
    int bad = 0;
    setup(0, 'h300, 'h340, 0, mk_ctrl(3, 0, 0, 0, 1, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(0, "R4");
    for (int i = base; i < tn; i++) if (!t_we[i] && t_addr[i] != 32'h300) bad++;
    check_eq("R4", "fixed source address", 32'(bad), 32'd0);
    check_eq("R4", "dst bytes", {mem['h340], mem['h341], mem['h342], 8'h0},
             {mem['h300], mem['h300], mem['h300], 8'h0});
    check_eq("R8", "no tc without bit31", 32'(tc_flag[0]), 32'd0);
  endtask

  task automatic t_pack();
    int base = tn;
    int rd = 0, wr = 0;
    setup(1, 'h400, 'h480, 0, mk_ctrl(2, 0, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(1, "R3");
    for (int i = base; i < tn; i++) begin
      if (!t_we[i] && t_size[i] == 2'd0) rd++;
      if (t_we[i] && t_size[i] == 2'd2) wr++;
    end
    check_eq("R3", "byte reads", 32'(rd), 32'd8);
    check_eq("R3", "word writes", 32'(wr), 32'd2);
    check_eq("R3", "packed word", rd32('h480), rd32('h400));
    cmp_bytes("R3", 'h400, 'h480, 8);
  endtask

  task automatic t_unpack();
    int base = tn;
    setup(1, 'h500, 'h580, 0, mk_ctrl(1, 2, 1, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(1, "R3");
    check_eq("R3", "beats word->half", 32'(tn - base), 32'd3);
    check_eq("R2", "second write address", t_addr[base+2], 32'h582);
    check_eq("R2", "half size code", 32'(t_size[base+1]), 32'd1);
    cmp_bytes("R3", 'h500, 'h580, 4);
  endtask

  task automatic t_chain();
    int base = tn;
    mem['h800] = 8'h00; mem['h801] = 8'h09; mem['h802] = 8'h00; mem['h803] = 8'h00;
    mem['h804] = 8'h00; mem['h805] = 8'h0A; mem['h806] = 8'h00; mem['h807] = 8'h00;
    for (int i = 0; i < 4; i++) mem['h808+i] = 8'h00;
    {mem['h80F], mem['h80E], mem['h80D], mem['h80C]} = mk_ctrl(2, 2, 2, 1, 1, 1);
    setup(1, 'h840, 'h860, 'h800, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(1, "R7");
    check_eq("R7", "link read 1", t_addr[base+2], 32'h800);
    check_eq("R7", "link read 2", t_addr[base+3], 32'h804);
    check_eq("R7", "link read 3", t_addr[base+4], 32'h80C);
    check_eq("R7", "link read 4", t_addr[base+5], 32'h808);
    cmp_bytes("R7", 'h840, 'h860, 4);
    cmp_bytes("R7", 'h900, 'hA00, 8);
    check_eq("R8", "tc from reloaded ctrl", 32'(tc_flag[1]), 32'd1);
    @(negedge clk); tc_clr = 3'b010; @(negedge clk); tc_clr = '0;
  endtask

  task automatic t_flow();
    periph_req = '0;
    setup(0, 'h140, 'h240, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 5, 1, 0));
    expect_quiet("R6", 30);
    periph_req[5] = 1'b1;
    wait_off(0, "R6");
    cmp_bytes("R6", 'h140, 'h240, 4);
    periph_req = 32'h20;
    setup(0, 'h150, 'h250, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 9, 5, 2, 0));
    expect_quiet("R6", 30);
    periph_req[9] = 1'b1;
    wait_off(0, "R6");
    cmp_bytes("R6", 'h150, 'h250, 4);
    periph_req = 32'h4;
    setup(0, 'h160, 'h260, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 2, 7, 3, 0));
    expect_quiet("R6", 30);
    periph_req[7] = 1'b1;
    wait_off(0, "R6");
    cmp_bytes("R6", 'h160, 'h260, 4);
    periph_req = '0;
  endtask

  task automatic t_halt_zero();
    setup(2, 'h170, 'h270, 0, mk_ctrl(2, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 1));
    expect_quiet("R5", 30);
    check_eq("R5", "halted channel still enabled", 32'(chan_en[2]), 32'd1);
    prog(2, 3'd4, mk_conf(1, 0, 0, 0, 0));
    wait_off(2, "R5");
    cmp_bytes("R5", 'h170, 'h270, 8);
    setup(2, 'h180, 'h280, 0, mk_ctrl(0, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    expect_quiet("R1", 30);
    check_eq("R1", "zero-count channel stays enabled", 32'(chan_en[2]), 32'd1);
    prog(2, 3'd4, 32'd0);
  endtask

  task automatic t_err();
    setup(2, 'h190, 'h290, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 5, 0));
    expect_quiet("R9", 30);
    check_eq("R9", "error flag raised", 32'(err_flag[2]), 32'd1);
    prog(2, 3'd4, 32'd0);
    @(negedge clk); err_clr = 3'b100; @(negedge clk); err_clr = '0; @(negedge clk);
    check_eq("R9", "error flag cleared", 32'(err_flag[2]), 32'd0);
  endtask

  task automatic t_glb();
    glb_en = 1'b0;
    setup(0, 'h1A0, 'h2A0, 0, mk_ctrl(2, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    expect_quiet("R10", 40);
    check_eq("R10", "channel waits while disabled", 32'(chan_en[0]), 32'd1);
    glb_en = 1'b1;
    wait_off(0, "R10");
    cmp_bytes("R10", 'h1A0, 'h2A0, 8);
  endtask

  task automatic t_arb();
    int base;
    glb_en = 1'b0;
    setup(2, 'hB00, 'hC00, 0, mk_ctrl(2, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    setup(1, 'hB40, 'hC40, 0, mk_ctrl(2, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    base = tn;
    glb_en = 1'b1;
    wait_off(2, "R11");
    n_checks++;
    if (!(last_wr(base, 'hC40, 'hC48) >= 0 &&
          last_wr(base, 'hC40, 'hC48) < first_wr(base, 'hC00, 'hC08))) begin
      n_fail++;
      $display("FAIL R11 lowest first: actual ch1_last=%0d expected below ch2_first=%0d",
               last_wr(base, 'hC40, 'hC48), first_wr(base, 'hC00, 'hC08));
    end
  endtask

  task automatic t_sticky();
    int base = tn;
    int t = 0;
    periph_req = '0;
    setup(0, 'hD00, 'hE00, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 3, 1, 0));
    setup(1, 'hD40, 'hE40, 0, mk_ctrl(3, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    while (first_wr(base, 'hE40, 'hE4C) < 0 && t < 2000) begin @(negedge clk); t++; end
    periph_req[3] = 1'b1;
    wait_off(1, "R11");
    wait_off(0, "R11");
    n_checks++;
    if (!(first_wr(base, 'hE00, 'hE04) > last_wr(base, 'hE40, 'hE4C))) begin
      n_fail++;
      $display("FAIL R11 sticky service: actual ch0_first=%0d expected above ch1_last=%0d",
               first_wr(base, 'hE00, 'hE04), last_wr(base, 'hE40, 'hE4C));
    end
    cmp_bytes("R11", 'hD40, 'hE40, 12);
    periph_req = '0;
  endtask

  task automatic t_oob();
    prog(3, 3'd3, mk_ctrl(2, 2, 2, 1, 1, 0));
    prog(3, 3'd4, mk_conf(1, 0, 0, 0, 0));
    expect_quiet("R13", 30);
    check_eq("R13", "out-of-range write ignored", 32'(chan_en), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    glb_en = 1'b1;
    t_basic();
    t_fixed_src();
    t_pack();
    t_unpack();
    t_chain();
    t_flow();
    t_halt_zero();
    t_err();
    t_glb();
    t_arb();
    t_sticky();
    t_oob();
    check_eq("R12", "request held through stalls", 32'(hs_viol), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule